// File: doc/BRIEF.md
# Four-Channel Double-Buffered DAC Register Bank

This block keeps the digital state of a four-channel digital-to-analog converter. Every channel has two 16-bit stages. A staging register takes new codes from a serial front end through a simple write port. A converter register drives the analog stage. A write fills the staging register of the selected channel and marks that channel as holding fresh data. A low level on the active-low load input then moves every marked channel into its converter register on the same clock edge, so all outputs change together. If the load input is held low all the time, the converter registers follow writes without any separate pulse.

A separate active-low clear pin acts on its falling edge. The pin is brought into the clock domain by a two-flop synchronizer with edge detection. A clear zeroes every staging and converter register and drops all fresh-data marks. It also enters a sticky clear mode that ends only when a write completes correctly, which the front end reports with its end-of-last-byte strobe. While the clear pin stays low, loads are ignored. A write that is in progress when the clear lands is discarded, and a front end that is in high-speed mode is told to leave it. Under synchronous reset, a power-up select input chooses between a zero start and a midscale start for every register.

Top module: `qdac_regbank`

## Requirements
- R1: While reset is high, every staging and converter register is set to 16'h8000 when pwr_mid is 1, or to 16'h0000 when pwr_mid is 0. After reset, clr_mode, wr_abort and hs_exit are 0.
- R2: A cycle with wr_stb high loads wr_data into the staging register of the channel given by wr_ch (0=A, 1=B, 2=C, 3=D) and marks that channel fresh. No converter output changes while load_n stays high.
- R3: A clock edge with load_n low copies every fresh channel's staging register into its converter register and clears its mark, all on that one edge. Channels that are not fresh keep their converter value.
- R4: With load_n held low, a write shows on the selected channel's output on the second rising edge after the strobe edge. On the first edge the output still holds its old value.
- R5: A falling edge on clr_n zeroes all staging registers, converter registers and fresh marks on the third rising clock edge after the fall. The output still holds its old value after the second edge.
- R6: While clr_n is low after a clear, load_n pulses change no converter output.
- R7: A clear sets clr_mode. clr_mode stays set after clr_n returns high. It drops on the edge that samples last_byte_stb of a write that was not aborted.
- R8: A clear that lands while wr_busy is high raises wr_abort until wr_busy falls. wr_stb and last_byte_stb seen while wr_abort is high are ignored.
- R9: A clear that lands while hs_mode is high raises hs_exit for exactly one cycle, in the same cycle that the registers read zero.
- R10: A clr_n pin held low produces only one clear. Writes made after it are kept and can be loaded once clr_n is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_mid | input | 1 | Power-up level select: 1 = midscale, 0 = zero |
| wr_ch | input | 2 | Channel selected for a write |
| wr_data | input | 16 | Write data |
| wr_stb | input | 1 | One-cycle write strobe |
| last_byte_stb | input | 1 | End of last byte of a write frame |
| wr_busy | input | 1 | Front end is in the middle of a write frame |
| hs_mode | input | 1 | Front end is in high-speed mode |
| load_n | input | 1 | Active-low transfer of fresh channels |
| clr_n | input | 1 | Asynchronous clear pin, acts on its falling edge |
| dac_out | output | 64 | Converter registers; channel n is at bits [16n+15:16n] |
| clr_mode | output | 1 | Sticky clear mode |
| wr_abort | output | 1 | A write is being discarded because of a clear |
| hs_exit | output | 1 | One-cycle request to leave high-speed mode |

## Verification
A fresh mark that is lost or stuck shows up at dac_out on the next load edge. Either a channel fails to move, or it takes an old staging value. A wrong synchronizer or edge detector shows up as a clear that arrives one edge early or late, or as a second clear that wipes data written while the pin was held low. Mistakes in abort or clear-mode handling show up at clr_mode and wr_abort within one cycle of the strobe that should, or should not, have been accepted.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef struct packed {
    logic clr_evt;
    logic clr_low;
    logic load_ok;
  } bank_ctl_t;

endpackage

// File: rtl/qdac_clr_sync.sv
module qdac_clr_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_pin_n,
  output logic clr_low,
  output logic clr_evt
);

  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], clr_pin_n};
      prev_q <= sync_q[TOP];
    end
  end

  assign clr_low = ~sync_q[TOP];
  assign clr_evt = prev_q & ~sync_q[TOP];

  // one event per falling edge, never two in a row
  assert_single_event_R10: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> !clr_evt);

endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic clr_evt,
  input  logic wr_busy,
  input  logic wr_stb,
  input  logic last_byte_stb,
  input  logic hs_mode,
  output logic wr_ok,
  output logic clr_mode,
  output logic wr_abort,
  output logic hs_exit
);

  logic last_ok;

  assign wr_ok   = wr_stb & ~wr_abort & ~clr_evt;
  assign last_ok = last_byte_stb & ~wr_abort & ~clr_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_mode <= 1'b0;
      wr_abort <= 1'b0;
      hs_exit  <= 1'b0;
    end else begin
      hs_exit <= clr_evt & hs_mode;
      if (clr_evt) begin
        clr_mode <= 1'b1;
        wr_abort <= wr_busy;
      end else begin
        if (last_ok) clr_mode <= 1'b0;
        if (!wr_busy) wr_abort <= 1'b0;
      end
    end
  end

  assert_clr_enters_mode_R7: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> clr_mode);

  assert_valid_last_exits_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_mode && last_byte_stb && !wr_abort && !clr_evt) |=> !clr_mode);

  assert_abort_on_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && wr_busy) |=> wr_abort);

  assert_aborted_last_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_abort && clr_mode) |=> clr_mode);

  assert_hs_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && hs_mode) |=> hs_exit ##1 !hs_exit);

endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
  import qdac_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_mid,
  input  bank_ctl_t         ctl,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dac_q
);

  localparam logic [DATA_W-1:0] MIDSCALE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] stage_q;
  logic              fresh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= pwr_mid ? MIDSCALE : '0;
      dac_q   <= pwr_mid ? MIDSCALE : '0;
      fresh_q <= 1'b0;
    end else if (ctl.clr_evt) begin
      stage_q <= '0;
      dac_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      if (ctl.load_ok && fresh_q) begin
        dac_q   <= stage_q;
        fresh_q <= 1'b0;
      end
      if (wr_en) begin
        stage_q <= wr_data;
        fresh_q <= 1'b1;
      end
    end
  end

  assert_reset_level_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dac_q == ($past(pwr_mid) ? MIDSCALE : '0)));

  assert_clear_zeroes_R5: assert property (@(posedge clk) disable iff (rst)
    ctl.clr_evt |=> (dac_q == '0 && stage_q == '0 && !fresh_q));

  assert_load_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl.clr_low && !ctl.clr_evt) |=> $stable(dac_q));

  assert_transfer_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl.load_ok && fresh_q && !wr_en && !ctl.clr_evt) |=>
      (!fresh_q && dac_q == $past(stage_q)));

  assert_no_load_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctl.load_ok && !ctl.clr_evt) |=> $stable(dac_q));

endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
  import qdac_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pwr_mid,
  input  logic [CH_W-1:0]          wr_ch,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     wr_stb,
  input  logic                     last_byte_stb,
  input  logic                     wr_busy,
  input  logic                     hs_mode,
  input  logic                     load_n,
  input  logic                     clr_n,
  output logic [NUM_CH*DATA_W-1:0] dac_out,
  output logic                     clr_mode,
  output logic                     wr_abort,
  output logic                     hs_exit
);

  bank_ctl_t ctl;
  logic      clr_low;
  logic      clr_evt;
  logic      wr_ok;

  qdac_clr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .clr_pin_n (clr_n),
    .clr_low   (clr_low),
    .clr_evt   (clr_evt)
  );

  qdac_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .clr_evt       (clr_evt),
    .wr_busy       (wr_busy),
    .wr_stb        (wr_stb),
    .last_byte_stb (last_byte_stb),
    .hs_mode       (hs_mode),
    .wr_ok         (wr_ok),
    .clr_mode      (clr_mode),
    .wr_abort      (wr_abort),
    .hs_exit       (hs_exit)
  );

  always_comb begin
    ctl.clr_evt = clr_evt;
    ctl.clr_low = clr_low;
    ctl.load_ok = ~load_n & ~clr_low & ~clr_evt;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel = wr_ok && (wr_ch == CH_W'(i));

    qdac_chan #(.DATA_W(DATA_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .pwr_mid (pwr_mid),
      .ctl     (ctl),
      .wr_en   (sel),
      .wr_data (wr_data),
      .dac_q   (dac_out[i*DATA_W +: DATA_W])
    );
  end

  // an aborted frame never writes
  assert_abort_blocks_write_R8: assert property (@(posedge clk) disable iff (rst)
    wr_abort |-> !wr_ok);

endmodule

// File: tb/test_qdac_regbank.sv
`timescale 1ns/1ps
module test_qdac_regbank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_mid = 1'b1;
  logic [1:0]  wr_ch = '0;
  logic [15:0] wr_data = '0;
  logic        wr_stb = 1'b0;
  logic        last_byte_stb = 1'b0;
  logic        wr_busy = 1'b0;
  logic        hs_mode = 1'b0;
  logic        load_n = 1'b1;
  logic        clr_n = 1'b1;
  logic [63:0] dac_out;
  logic        clr_mode, wr_abort, hs_exit;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [15:0] exp_v [4];

  always #2 clk = ~clk;

  qdac_regbank i_qdac_regbank (
    .clk(clk), .rst(rst), .pwr_mid(pwr_mid), .wr_ch(wr_ch), .wr_data(wr_data),
    .wr_stb(wr_stb), .last_byte_stb(last_byte_stb), .wr_busy(wr_busy),
    .hs_mode(hs_mode), .load_n(load_n), .clr_n(clr_n), .dac_out(dac_out),
    .clr_mode(clr_mode), .wr_abort(wr_abort), .hs_exit(hs_exit)
  );

  function automatic logic [15:0] dac(input int ch);
    return dac_out[ch*16 +: 16];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input int ch, input logic [15:0] d);
    wr_ch = 2'(ch); wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic pulse_load;
    load_n = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
  endtask

  task automatic pulse_last;
    last_byte_stb = 1'b1;
    @(negedge clk);
    last_byte_stb = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < 4; c++) chk(req, 32'(dac(c)), 32'(exp_v[c]));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    nchk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1: midscale start
    for (int c = 0; c < 4; c++) exp_v[c] = 16'h8000;
    check_all("R1 midscale");
    chk("R1 clr_mode", 32'(clr_mode), 0);
    chk("R1 wr_abort", 32'(wr_abort), 0);
    chk("R1 hs_exit", 32'(hs_exit), 0);

    // R2: sweep every channel with walking patterns; outputs must not move
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 16; b++) begin
        do_write(c, (16'h1 << b) ^ 16'(c));
        check_all("R2 no change without load");
      end

    // R3: the last pattern of each channel is now fresh
    pulse_load();
    for (int c = 0; c < 4; c++) exp_v[c] = 16'h8000 ^ 16'(c);
    check_all("R3 all fresh transfer");

    // R3: every subset of fresh channels
    for (int m = 1; m < 16; m++) begin
      for (int c = 0; c < 4; c++)
        if (m[c]) do_write(c, {4'(m), 4'(c), 8'h5A ^ 8'(m * 7)});
      pulse_load();
      for (int c = 0; c < 4; c++)
        if (m[c]) exp_v[c] = {4'(m), 4'(c), 8'h5A ^ 8'(m * 7)};
      check_all("R3 subset transfer");
      pulse_load();
      check_all("R3 no stale transfer");
    end

    // R4: load held low
    load_n = 1'b0;
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 3; k++) begin
        logic [15:0] v;
        v = 16'h1111 * 16'(k + 1) + 16'(c << 12) + 16'h0101;
        do_write(c, v);
        chk("R4 old value after first edge", 32'(dac(c)), 32'(exp_v[c]));
        step(1);
        exp_v[c] = v;
        chk("R4 new value after second edge", 32'(dac(c)), 32'(v));
      end
    load_n = 1'b1;
    step(1);

    // R5 + R9: clear while in high-speed mode
    hs_mode = 1'b1;
    clr_n = 1'b0;
    step(2);
    chk("R5 not yet cleared", 32'(dac(3)), 32'(exp_v[3]));
    step(1);
    for (int c = 0; c < 4; c++) exp_v[c] = 16'h0000;
    check_all("R5 cleared");
    chk("R7 clr_mode set", 32'(clr_mode), 1);
    chk("R9 hs_exit pulse", 32'(hs_exit), 1);
    step(1);
    chk("R9 hs_exit one cycle", 32'(hs_exit), 0);
    hs_mode = 1'b0;

    // R6: loads ignored while pin low
    do_write(1, 16'h1234);
    pulse_load();
    chk("R6 load ignored", 32'(dac(1)), 0);
    step(4);
    chk("R10 clr_mode held", 32'(clr_mode), 1);
    check_all("R10 no repeated clear");
    clr_n = 1'b1;
    step(3);
    pulse_load();
    exp_v[1] = 16'h1234;
    check_all("R10 write during low kept");
    chk("R7 mode survives pin release", 32'(clr_mode), 1);
    pulse_last();
    chk("R7 valid last byte exits", 32'(clr_mode), 0);

    // R8 + R5: clear during a busy frame
    wr_busy = 1'b1;
    do_write(0, 16'h7777);
    clr_n = 1'b0;
    step(3);
    for (int c = 0; c < 4; c++) exp_v[c] = 16'h0000;
    chk("R8 wr_abort set", 32'(wr_abort), 1);
    chk("R7 clr_mode set again", 32'(clr_mode), 1);
    check_all("R5 second clear");
    do_write(2, 16'hBEEF);
    pulse_last();
    chk("R8 aborted last ignored", 32'(clr_mode), 1);
    wr_busy = 1'b0;
    step(1);
    chk("R8 abort drops with busy", 32'(wr_abort), 0);
    clr_n = 1'b1;
    step(3);
    pulse_load();
    chk("R8 aborted write discarded", 32'(dac(2)), 0);
    chk("R5 fresh mark cleared", 32'(dac(0)), 0);
    do_write(3, 16'h00C3);
    pulse_last();
    pulse_load();
    exp_v[3] = 16'h00C3;
    check_all("R3 after clear mode");
    chk("R7 exit after valid frame", 32'(clr_mode), 0);

    // R1: zero start
    pwr_mid = 1'b0;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(1);
    for (int c = 0; c < 4; c++) exp_v[c] = 16'h0000;
    check_all("R1 zero start");
    chk("R1 clr_mode after reset", 32'(clr_mode), 0);
    finish_run();
  end

endmodule